// File: doc/BRIEF.md
# Coprocessor Access Permission Checker

This block decides, for every coprocessor instruction, whether the issuing context may use the coprocessor it targets. It holds a 32-bit access control register and a 14-bit legacy enable register. Both are written and read back through a small system-register port. From the instruction word it takes the 4-bit coprocessor number. It then forms a combinational grant or deny verdict from that number, the current privilege level and the stored permissions. A denial is reported only as the verdict. Raising the exception that follows is left to the pipeline.

Coprocessors 0 to 13 each own a two-bit permission field in the access register. Only the fields of coprocessors that are built into the chip can be written. With the floating-point unit present, those are coprocessors 10 and 11. All other fields stay at zero, so those coprocessors are always denied. A mode input switches the verdict to a legacy scheme. In that scheme one enable bit per coprocessor replaces the two-bit fields and the privilege level plays no part. Coprocessors 14 and 15 always pass this block.

Top module: `cop_access_gate`

## Requirements
- R1: After reset, both registers read back as zero and every coprocessor numbered 0 to 13 is denied, in both modes and at both privilege levels.
- R2: A write with `wr_sel`=0 stores `wr_data` AND 0x00F00000 into the access register, which is the mask for coprocessors 10 and 11 with the floating-point unit present. Bits outside that mask read as zero and have no effect on any verdict.
- R3: A write with `wr_sel`=1 stores `wr_data[13:0]` into the legacy enable register. `rd_data[31:14]` reads as zero when `rd_sel`=1.
- R4: In normal mode (`legacy_mode`=0), a coprocessor below 14 whose field, at bits [2n+1:2n] for coprocessor n, holds 0 is denied.
- R5: In normal mode, a field value of 1 grants access when `user_mode`=0 and denies it when `user_mode`=1.
- R6: In normal mode, the reserved field value 2 denies access at both privilege levels.
- R7: In normal mode, a field value of 3 grants access at both privilege levels.
- R8: Coprocessor numbers 14 and 15 are granted whatever the register contents, mode and privilege level.
- R9: In legacy mode (`legacy_mode`=1), a coprocessor n below 14 is granted exactly when bit n of the legacy enable register is set, at either privilege level and regardless of the access register.
- R10: A write changes the verdict and the readback only from the clock cycle after the rising edge that captures it. A write to one register leaves the other register unchanged.
- R11: The coprocessor number is `insn[11:8]`. All other instruction bits have no effect on the verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 access register, 1 legacy enable register |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Readback select: 0 access register, 1 legacy enable register |
| rd_data | output | 32 | Readback of the selected register, masked bits as zero |
| legacy_mode | input | 1 | 1 selects the per-bit legacy enable scheme |
| user_mode | input | 1 | 1 when the instruction runs unprivileged |
| insn | input | 32 | Coprocessor instruction word |
| grant | output | 1 | 1 when the instruction may proceed |

## Verification
`grant` and `rd_data` are pure combinational functions of the inputs and the two registers. They are due in the same cycle as a change of `insn`, `user_mode`, `legacy_mode` or `rd_sel`. A register write becomes visible only after the next rising edge. The bench drives every input just after a falling edge and samples a short delay later, well before the next rising edge. For the write-timing case, it samples once while the write strobe is still high, where the old verdict is expected, and once on the following falling edge, where the new verdict is expected.

// File: rtl/cop_gate_pkg.sv
package cop_gate_pkg;

  localparam int REG_W       = 32;
  localparam int NUM_CHECKED = 14;
  localparam int FIELD_W     = 2;
  localparam int COP_NUM_W   = 4;
  localparam int COP_LSB     = 8;
  localparam int COP_SPACE   = 1 << COP_NUM_W;

  typedef enum logic [FIELD_W-1:0] {
    PERM_NONE = 2'd0,
    PERM_PRIV = 2'd1,
    PERM_RSVD = 2'd2,
    PERM_ALL  = 2'd3
  } perm_code_t;

  // Bit mask of the access register covering the fields of implemented coprocessors
  function automatic logic [REG_W-1:0] field_mask(input logic [NUM_CHECKED-1:0] impl);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CHECKED; i++) begin
      if (impl[i]) m[FIELD_W*i +: FIELD_W] = '1;
    end
    return m;
  endfunction

  // Whether one permission code lets an instruction through at the given level
  function automatic logic perm_allows(input perm_code_t code, input logic user);
    logic ok;
    unique case (code)
      PERM_ALL:  ok = 1'b1;
      PERM_PRIV: ok = !user;
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/cop_perm_regs.sv
module cop_perm_regs
  import cop_gate_pkg::*;
#(
  parameter logic [REG_W-1:0] ACC_MASK = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   wr_sel,
  input  logic [REG_W-1:0]       wr_data,
  output logic [REG_W-1:0]       acc_q,
  output logic [NUM_CHECKED-1:0] leg_q
);

  logic acc_wr;
  logic leg_wr;

  assign acc_wr = wr_en && !wr_sel;
  assign leg_wr = wr_en &&  wr_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_wr) begin
      acc_q <= wr_data & ACC_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      leg_q <= '0;
    end else if (leg_wr) begin
      leg_q <= wr_data[NUM_CHECKED-1:0];
    end
  end

endmodule

// File: rtl/cop_field_check.sv
module cop_field_check
  import cop_gate_pkg::*;
(
  input  logic [REG_W-1:0]       acc_q,
  input  logic                   user_mode,
  output logic [NUM_CHECKED-1:0] field_ok
);

  for (genvar i = 0; i < NUM_CHECKED; i++) begin : g_field
    perm_code_t code;
    assign code        = perm_code_t'(acc_q[FIELD_W*i +: FIELD_W]);
    assign field_ok[i] = perm_allows(code, user_mode);
  end

  logic unused_acc_top;
  assign unused_acc_top = ^acc_q[REG_W-1:FIELD_W*NUM_CHECKED];

endmodule

// File: rtl/cop_verdict_mux.sv
module cop_verdict_mux
  import cop_gate_pkg::*;
(
  input  logic [COP_NUM_W-1:0]   cop_num,
  input  logic                   legacy_mode,
  input  logic [NUM_CHECKED-1:0] field_ok,
  input  logic [NUM_CHECKED-1:0] leg_q,
  output logic                   checked,
  output logic                   grant
);

  localparam int PAD_W = COP_SPACE - NUM_CHECKED;

  logic [COP_SPACE-1:0] ok_norm;
  logic [COP_SPACE-1:0] ok_leg;

  // Numbers above the checked range are padded with ones: always let through
  assign ok_norm = {{PAD_W{1'b1}}, field_ok};
  assign ok_leg  = {{PAD_W{1'b1}}, leg_q};

  assign checked = (int'(cop_num) < NUM_CHECKED);
  assign grant   = legacy_mode ? ok_leg[cop_num] : ok_norm[cop_num];

endmodule

// File: rtl/cop_access_gate.sv
module cop_access_gate
  import cop_gate_pkg::*;
#(
  parameter bit HAS_FPU = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [REG_W-1:0] rd_data,
  input  logic             legacy_mode,
  input  logic             user_mode,
  input  logic [REG_W-1:0] insn,
  output logic             grant
);

  localparam logic [NUM_CHECKED-1:0] IMPL_COPS = HAS_FPU ? 14'h0C00 : 14'h0000;
  localparam logic [REG_W-1:0]       ACC_MASK  = field_mask(IMPL_COPS);

  logic [REG_W-1:0]       acc_q;
  logic [NUM_CHECKED-1:0] leg_q;
  logic [NUM_CHECKED-1:0] field_ok;
  logic [COP_NUM_W-1:0]   cop_num;
  logic                   checked;
  logic [REG_W-1:0]       acc_wmask;

  assign acc_wmask = ACC_MASK;
  assign cop_num   = insn[COP_LSB +: COP_NUM_W];

  logic unused_insn_bits;
  assign unused_insn_bits = ^{insn[REG_W-1:COP_LSB+COP_NUM_W], insn[COP_LSB-1:0]};

  cop_perm_regs #(.ACC_MASK(ACC_MASK)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .acc_q   (acc_q),
    .leg_q   (leg_q)
  );

  cop_field_check u_fields (
    .acc_q     (acc_q),
    .user_mode (user_mode),
    .field_ok  (field_ok)
  );

  cop_verdict_mux u_mux (
    .cop_num     (cop_num),
    .legacy_mode (legacy_mode),
    .field_ok    (field_ok),
    .leg_q       (leg_q),
    .checked     (checked),
    .grant       (grant)
  );

  assign rd_data = rd_sel ? {{(REG_W-NUM_CHECKED){1'b0}}, leg_q} : acc_q;

endmodule

// File: rtl/cop_access_gate_chk.sv
module cop_access_gate_chk
  import cop_gate_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic                   wr_sel,
  input logic [REG_W-1:0]       wr_data,
  input logic                   legacy_mode,
  input logic                   user_mode,
  input logic [COP_NUM_W-1:0]   cop_num,
  input logic                   checked,
  input logic                   grant,
  input logic [REG_W-1:0]       acc_q,
  input logic [NUM_CHECKED-1:0] leg_q,
  input logic [REG_W-1:0]       acc_wmask
);

  logic [FIELD_W-1:0] cur_field;
  assign cur_field = acc_q[FIELD_W*cop_num +: FIELD_W];

  // R2
  acc_write_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (acc_q == ($past(wr_data) & acc_wmask)));

  // R3
  leg_write_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (leg_q == $past(wr_data[NUM_CHECKED-1:0])));

  // R10
  leg_write_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> $stable(acc_q));

  // R10
  acc_write_keeps_leg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> $stable(leg_q));

  // R8
  high_cop_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !checked |-> grant);

  // R6
  reserved_denies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (checked && !legacy_mode && cur_field == PERM_RSVD) |-> !grant);

  // R5
  priv_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (checked && !legacy_mode && cur_field == PERM_PRIV) |-> (grant == !user_mode));

  // R9
  legacy_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (checked && legacy_mode) |-> (grant == leg_q[cop_num]));

endmodule

bind cop_access_gate cop_access_gate_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .legacy_mode (legacy_mode),
  .user_mode   (user_mode),
  .cop_num     (cop_num),
  .checked     (checked),
  .grant       (grant),
  .acc_q       (acc_q),
  .leg_q       (leg_q),
  .acc_wmask   (acc_wmask)
);

// File: tb/sim_cop_access_gate.sv
`timescale 1ns/1ps
module sim_cop_access_gate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        legacy_mode = 1'b0;
  logic        user_mode = 1'b0;
  logic [31:0] insn = '0;
  logic        grant;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Bench-side copies of what the registers should hold
  logic [31:0] exp_acc = '0;
  logic [13:0] exp_leg = '0;

  always #2 clk = ~clk;

  cop_access_gate u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .legacy_mode(legacy_mode),
    .user_mode(user_mode), .insn(insn), .grant(grant)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected verdict, restated from the requirements
  function automatic bit want_grant(input int cop, input bit user, input bit legacy);
    int code;
    if (cop >= 14) return 1'b1;
    if (legacy) return exp_leg[cop];
    code = int'((exp_acc >> (2*cop)) & 32'h3);
    case (code)
      3: return 1'b1;
      1: return user ? 1'b0 : 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic probe(input int cop, input bit user, input bit legacy, input logic [31:0] filler, input string req);
    insn = (filler & ~32'h0000_0F00) | (32'(cop) << 8);
    user_mode = user;
    legacy_mode = legacy;
    #0.5;
    check(grant == want_grant(cop, user, legacy), req, {31'b0, grant}, {31'b0, want_grant(cop, user, legacy)});
  endtask

  task automatic write_reg(input bit sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel) exp_leg = data[13:0];
    else     exp_acc = data & 32'h00F0_0000;
  endtask

  task automatic readback(input bit sel, input string req);
    logic [31:0] e;
    rd_sel = sel;
    #0.5;
    e = sel ? {18'b0, exp_leg} : exp_acc;
    check(rd_data === e, req, rd_data, e);
  endtask

  task automatic t_reset;
    readback(1'b0, "R1 access reg zero");
    readback(1'b1, "R1 legacy reg zero");
    for (int c = 0; c < 14; c++) begin
      probe(c, 1'b0, 1'b0, 32'h0, "R1 priv normal");
      probe(c, 1'b1, 1'b0, 32'h0, "R1 user normal");
      probe(c, 1'b0, 1'b1, 32'h0, "R1 priv legacy");
    end
  endtask

  task automatic t_access_mask;
    write_reg(1'b0, 32'hFFFF_FFFF);
    readback(1'b0, "R2 all-ones masked");
    readback(1'b1, "R10 legacy untouched");
    for (int c = 0; c < 14; c++) probe(c, 1'b1, 1'b0, 32'h0, "R2 unimplemented field denies");
    write_reg(1'b0, 32'h5A5A_5A5A);
    readback(1'b0, "R2 pattern masked");
  endtask

  task automatic t_legacy_mask;
    write_reg(1'b1, 32'hFFFF_FFFF);
    readback(1'b1, "R3 legacy low bits");
    readback(1'b0, "R10 access untouched");
    write_reg(1'b1, 32'hABCD_2A5C);
    readback(1'b1, "R3 legacy pattern");
  endtask

  task automatic t_codes;
    for (int k = 0; k < 4; k++) begin
      write_reg(1'b0, (32'(k) << 20) | (32'(3 - k) << 22));
      probe(10, 1'b0, 1'b0, 32'h0, "R4 R5 R6 R7 cop10 priv");
      probe(10, 1'b1, 1'b0, 32'h0, "R4 R5 R6 R7 cop10 user");
      probe(11, 1'b0, 1'b0, 32'h0, "R4 R5 R6 R7 cop11 priv");
      probe(11, 1'b1, 1'b0, 32'h0, "R4 R5 R6 R7 cop11 user");
    end
    // Reserved code on both fields, explicit
    write_reg(1'b0, 32'h00A0_0000);
    probe(10, 1'b0, 1'b0, 32'h0, "R6 reserved priv");
    probe(11, 1'b1, 1'b0, 32'h0, "R6 reserved user");
  endtask

  task automatic t_high;
    write_reg(1'b0, 32'h0);
    write_reg(1'b1, 32'h0);
    for (int c = 14; c < 16; c++) begin
      probe(c, 1'b0, 1'b0, 32'h0, "R8 high cop priv normal");
      probe(c, 1'b1, 1'b0, 32'h0, "R8 high cop user normal");
      probe(c, 1'b1, 1'b1, 32'h0, "R8 high cop user legacy");
    end
  endtask

  task automatic t_legacy;
    write_reg(1'b0, 32'h00F0_0000);
    write_reg(1'b1, 32'h0000_2A5C);
    for (int c = 0; c < 14; c++) begin
      probe(c, 1'b0, 1'b1, 32'h0, "R9 legacy priv");
      probe(c, 1'b1, 1'b1, 32'h0, "R9 legacy user");
    end
  endtask

  task automatic t_timing;
    write_reg(1'b0, 32'h0);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0030_0000;
    insn = 32'h0000_0A00; user_mode = 1'b1; legacy_mode = 1'b0; rd_sel = 1'b0;
    #0.5;
    check(grant == 1'b0, "R10 before edge verdict old", {31'b0, grant}, 32'h0);
    check(rd_data == 32'h0, "R10 before edge readback old", rd_data, 32'h0);
    @(negedge clk);
    wr_en = 1'b0;
    exp_acc = 32'h0030_0000;
    #0.5;
    check(grant == 1'b1, "R10 after edge verdict new", {31'b0, grant}, 32'h1);
    readback(1'b0, "R10 after edge readback new");
  endtask

  task automatic t_insn;
    write_reg(1'b0, 32'h0010_0000);
    write_reg(1'b1, 32'h0000_0800);
    probe(10, 1'b1, 1'b0, 32'hFFFF_FFFF, "R11 filler ones cop10");
    probe(10, 1'b0, 1'b0, 32'hFFFF_FFFF, "R11 filler ones cop10 priv");
    probe(11, 1'b0, 1'b0, 32'h1234_5678, "R11 filler mixed cop11");
    probe(11, 1'b0, 1'b1, 32'hF0F0_F0F0, "R11 filler legacy cop11");
    probe(14, 1'b1, 1'b0, 32'hFFFF_F0FF, "R11 filler cop14");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_access_mask();
    t_legacy_mask();
    t_codes();
    t_high();
    t_legacy();
    t_timing();
    t_insn();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule